// File: doc/BRIEF.md
# Two-Way Single-Message Mailbox

This block lets two bus masters, a secure controller and an application processor, hand 32-bit messages to each other. Each direction has one message slot that is either empty or full. Both masters reach the block through one shared register port. A requester-ID bit comes with every access and decides how that access is treated. The sender of a slot may fill it only while it is empty. The recipient of a slot drains it by reading it. While a slot holds a message, the recipient's interrupt is asserted if that recipient has enabled it.

Software on each side typically enables its own interrupt once. It then waits for the interrupt, reads its incoming slot and, before posting a reply, checks the status register to see whether the outgoing slot is free.

Top module: `dual_mailbox`

## Requirements
- R1: After reset both slots are empty, both interrupt enables are 0, both interrupt outputs are low, and the status register reads 0.
- R2: The requester ID is 0 for the secure controller and 1 for the application processor. Slot A at offset 0x000 carries messages from the application processor (ID 1) to the secure controller. Slot B at offset 0x004 carries messages the other way. A write by a slot's sender while the slot is empty stores the data, and the slot is full from the next cycle.
- R3: A read by a slot's recipient while the slot is full returns the stored message in the same cycle. From the next cycle the slot is empty.
- R4: A write by a slot's sender while the slot is full is ignored, and the message already held is kept unchanged.
- R5: Writes to a slot by its recipient are ignored. Reads of a slot by its sender return 0. Reads by the recipient while the slot is empty return 0 and leave the state unchanged.
- R6: The secure controller's enable is bit 0 at offset 0x100, and the application processor's enable is bit 0 at offset 0x104. The owner of an enable reads it back and writes it. A write from the other side is ignored, and a read from the other side returns 0.
- R7: The secure interrupt equals the full flag of slot A ANDed with the secure enable. The application interrupt equals the full flag of slot B ANDed with the application enable. Both are level signals. If an enable is set while its slot is full, the interrupt rises in the next cycle.
- R8: The status register at 0x108 returns the full flag of slot A in bit 0 and the full flag of slot B in bit 1, with all other bits 0. Either requester may read it, and writes to it change nothing.
- R9: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_src_i | input | 1 | Requester ID: 0 = secure controller, 1 = application processor |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as a read |
| irq_sec_o | output | 1 | Interrupt to the secure controller |
| irq_app_o | output | 1 | Interrupt to the application processor |

## Verification
The two events that share a clock edge are the recipient's draining read and the fall of the interrupt. A single read must return the message and also empty the slot, so the interrupt drops at the edge that ends that read. If the sender refills the slot in the very next cycle, the refill must be accepted, and the interrupt must rise again one cycle later. Directed back-to-back drain-and-refill sequences provoke this. A long seeded random mix of both requesters over all offsets, including unmapped ones, provokes it as well. A reference model in the bench judges every read value, and it judges both interrupt levels after every edge.

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int EN_BASE = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              bus_src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_sec_o,
  output logic              irq_app_o
);
  localparam int STAT_OFS = EN_BASE + 8;

  logic [1:0]        full_q, en_q, push, pop, hit_msg, hit_en, own_en;
  logic [DATA_W-1:0] msg_q [2];
  logic              wr, rd, hit_stat;

  assign wr       = bus_valid_i & bus_write_i;
  assign rd       = bus_valid_i & ~bus_write_i;
  assign hit_stat = bus_addr_i == ADDR_W'(STAT_OFS);

  for (genvar k = 0; k < 2; k++) begin : g_slot
    localparam logic SENDER = (k == 0);
    assign hit_msg[k] = bus_addr_i == ADDR_W'(4 * k);
    assign hit_en[k]  = bus_addr_i == ADDR_W'(EN_BASE + 4 * k);
    assign own_en[k]  = hit_en[k] & (bus_src_i == 1'(k));
    assign push[k]    = wr & hit_msg[k] & (bus_src_i == SENDER) & ~full_q[k];
    assign pop[k]     = rd & hit_msg[k] & (bus_src_i != SENDER) & full_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[k] <= 1'b0;
        msg_q[k]  <= '0;
        en_q[k]   <= 1'b0;
      end else begin
        if (push[k]) begin
          full_q[k] <= 1'b1;
          msg_q[k]  <= bus_wdata_i;
        end else if (pop[k]) begin
          full_q[k] <= 1'b0;
        end
        if (wr && own_en[k]) en_q[k] <= bus_wdata_i[0];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (pop[0])         bus_rdata_o = msg_q[0];
      else if (pop[1])    bus_rdata_o = msg_q[1];
      else if (own_en[0]) bus_rdata_o = DATA_W'(en_q[0]);
      else if (own_en[1]) bus_rdata_o = DATA_W'(en_q[1]);
      else if (hit_stat)  bus_rdata_o = DATA_W'(full_q);
    end
  end

  assign irq_sec_o = full_q[0] & en_q[0];
  assign irq_app_o = full_q[1] & en_q[1];
endmodule

// File: rtl/dual_mailbox_chk.sv
module dual_mailbox_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int EN_BASE = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic              bus_src_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_sec_o,
  input logic              irq_app_o,
  input logic [1:0]        full_q,
  input logic [DATA_W-1:0] msg_a,
  input logic [DATA_W-1:0] msg_b
);
  logic app_wr_a, sec_rd_a;
  assign app_wr_a = bus_valid_i & bus_write_i & bus_src_i & (bus_addr_i == '0);
  assign sec_rd_a = bus_valid_i & ~bus_write_i & ~bus_src_i & (bus_addr_i == '0);

  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_a && !full_q[0] |=> full_q[0]);

  p_drain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_rd_a && full_q[0] |=> !full_q[0]);

  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_a && full_q[0] |=> $stable(msg_a) && full_q[0]);

  p_sender_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && !bus_write_i && bus_src_i && bus_addr_i == '0 |-> bus_rdata_o == '0);

  p_irq_sec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_sec_o |-> full_q[0]);

  p_irq_app_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_app_o |-> full_q[1]);

  p_status_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(EN_BASE + 8)
    |=> $stable(full_q) && $stable(msg_b));
endmodule

bind dual_mailbox dual_mailbox_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_BASE(EN_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
  .bus_src_i(bus_src_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .irq_sec_o(irq_sec_o), .irq_app_o(irq_app_o), .full_q(full_q),
  .msg_a(msg_q[0]), .msg_b(msg_q[1]));

// File: tb/sim_dual_mailbox.sv
`timescale 1ns/1ps
module sim_dual_mailbox;
  localparam logic SEC = 1'b0, APP = 1'b1;
  logic clk = 0, rst_n = 0;
  logic valid = 0, write = 0, src = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_sec, irq_app;
  int checks = 0, fails = 0;

  logic [1:0]  m_full = '0, m_en = '0;
  logic [31:0] m_msg [2] = '{32'h0, 32'h0};

  always #4 clk = ~clk;

  dual_mailbox u0 (.clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_src_i(src), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_sec_o(irq_sec), .irq_app_o(irq_app));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int slot_of(logic [11:0] a);
    if (a == 12'h000) return 0;
    if (a == 12'h004) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(logic s, logic [11:0] a);
    int k = slot_of(a);
    if (k >= 0) return (s != (k == 0) && m_full[k]) ? m_msg[k] : 32'h0;
    if (a == 12'h100) return (s == SEC) ? {31'h0, m_en[0]} : 32'h0;
    if (a == 12'h104) return (s == APP) ? {31'h0, m_en[1]} : 32'h0;
    if (a == 12'h108) return {30'h0, m_full};
    return 32'h0;
  endfunction

  function automatic string tag_of(logic s, logic [11:0] a);
    int k = slot_of(a);
    if (k >= 0) return (s != (k == 0) && m_full[k]) ? "R3" : "R5";
    if (a == 12'h100 || a == 12'h104) return "R6";
    if (a == 12'h108) return "R8";
    return "R9";
  endfunction

  task automatic access(logic w, logic s, logic [11:0] a, logic [31:0] d);
    int k;
    string t;
    @(negedge clk);
    valid = 1; write = w; src = s; addr = a; wdata = d;
    #1;
    t = tag_of(s, a);
    if (!w) chk(t, rdata, exp_read(s, a));
    k = slot_of(a);
    @(posedge clk);
    #1;
    valid = 0;
    if (k >= 0) begin
      if (w && s == (k == 0) && !m_full[k]) begin m_full[k] = 1; m_msg[k] = d; end
      else if (!w && s != (k == 0) && m_full[k]) m_full[k] = 0;
    end
    if (w && a == 12'h100 && s == SEC) m_en[0] = d[0];
    if (w && a == 12'h104 && s == APP) m_en[1] = d[0];
    chk("R7 sec", {31'h0, irq_sec}, {31'h0, m_full[0] & m_en[0]});
    chk("R7 app", {31'h0, irq_app}, {31'h0, m_full[1] & m_en[1]});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] offs [6] = '{12'h000, 12'h004, 12'h100, 12'h104, 12'h108, 12'h10C};
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq_sec", {31'h0, irq_sec}, 32'h0);
    chk("R1 irq_app", {31'h0, irq_app}, 32'h0);
    rst_n = 1;
    access(0, SEC, 12'h108, 0);
    access(0, APP, 12'h104, 0);
    access(1, APP, 12'h000, 32'hCAFE_0001);
    access(1, APP, 12'h000, 32'hDEAD_BEEF);
    access(0, APP, 12'h000, 0);
    access(1, SEC, 12'h000, 32'h1234_5678);
    access(0, APP, 12'h108, 0);
    access(1, APP, 12'h100, 1);
    access(0, APP, 12'h100, 0);
    access(1, SEC, 12'h100, 1);
    access(0, SEC, 12'h100, 0);
    access(0, SEC, 12'h000, 0);
    access(1, APP, 12'h000, 32'hA5A5_0002);
    access(0, SEC, 12'h000, 0);
    access(0, SEC, 12'h000, 0);
    access(1, SEC, 12'h108, 32'hFFFF_FFFF);
    access(1, SEC, 12'h004, 32'h0BAD_F00D);
    access(1, APP, 12'h104, 1);
    access(0, APP, 12'h004, 0);
    access(1, SEC, 12'h7F0, 32'hFFFF_FFFF);
    access(0, SEC, 12'h7F0, 0);
    access(0, SEC, 12'h108, 0);
    for (int i = 0; i < 4000; i++) begin
      logic w = 1'($urandom);
      logic s = 1'($urandom);
      logic [11:0] a = offs[$urandom % 6];
      access(w, s, a, $urandom);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule